// File: doc/BRIEF.md
# Manchester Clock Acquisition Decoder

This receiver recovers a bit clock and serial data from a Manchester-coded line. A phase accumulator stands in for an oscillator running at four times the bit rate. Its top two bits give the four quarter-bit phases of the cell. One full wrap of the accumulator is one bit cell, and the top bit acts as the internal recovered clock. While the qualified carrier input is low, the accumulator free-runs. A pulse from the local transmit timing returns it to zero phase.

Once carrier rises, the block waits for the first falling mid-cell transition, which is a Manchester zero. That transition halts the accumulator with its phase preset to mid-cell, so the internal clock is high. The next falling transition, at the centre of bit 4 of a 1010 preamble, restarts the accumulator from mid-cell and declares lock. From then on, each transition that lands in the middle half of a cell measures the phase error. Only a bounded fraction of that error is fed back, which keeps the sample point at the quarter-bit position and smooths out edge jitter.

The output clock enable pulses once per cell at the quarter-bit point, starting in cell 5. The data output presents the bit strobed at the previous pulse.

Top module: `manch_acq_rx`

## Requirements
- R1: During and right after reset, `locked` and `rclk_en` are 0 and `rx_data` is 1.
- R2: While carrier is low, `locked` and `rclk_en` stay 0 and `rx_data` stays 1. In this idle state, each `tx_tick` restarts the oscillator at zero phase.
- R3: The line idles low when carrier rises. A zero is high-then-low and a one is low-then-high, with the defining transition at mid-cell. Rising transitions and the first falling transition never give lock or any `rclk_en` pulse.
- R4: `locked` is 0 up to the cycle of the second falling transition after carrier rises, and is 1 from the next cycle on.
- R5: The first `rclk_en` pulse is visible 13 clock cycles after the second falling transition is driven, at the quarter-bit point of cell 5. This holds with a step of 16 phase units per clock, that is, 16 clocks per cell.
- R6: `rclk_en` is a single-cycle pulse, issued once per cell.
- R7: The first pulse shows `rx_data` = 1. Pulse n (n >= 2) shows the bit of cell 4+n-1, decoded as the inverse of the line in the first half of that cell.
- R8: After lock, only transitions in the middle half of a cell adjust the phase. Each correction is at most one tenth of the measured error. With mid-cell edges jittered by up to ±2 clocks, the spacing of `rclk_en` pulses stays within 15 to 17 clocks.
- R9: If carrier falls before the second falling transition, the block returns to idle without asserting `locked`, and a later packet still acquires.
- R10: If carrier falls after lock, `locked` and `rclk_en` are 0 and `rx_data` is 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock (STEP phase units per cycle) |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_tick | input | 1 | Bit-rate pulse from local transmit timing, aligns idle phase |
| carrier | input | 1 | Qualified carrier present flag |
| rx_line | input | 1 | Sampled Manchester line |
| rclk_en | output | 1 | Recovered clock enable, one pulse per cell at quarter bit |
| rx_data | output | 1 | Decoded serial data, high when not locked |
| locked | output | 1 | Acquisition complete |

## Verification
The assertions assume that every packet opens on a clean line-low 1010 preamble. This makes the first falling transition after carrier the centre of bit 2. They also assume that jitter never moves a mid-cell edge out of the middle half of its cell. This keeps correction windows separate from the cell-boundary transitions. The stimulus keeps the preamble cells unjittered and limits payload jitter to ±2 clocks of a 16-clock cell, well inside the ±4-clock window. Every packet ends with a clean trailer cell before carrier drops, so the last payload bit is strobed out before the block goes idle.

// File: rtl/manch_acq_rx.sv
module manch_acq_rx #(
  parameter int PW         = 8,
  parameter int STEP       = 16,
  parameter int CORR_NUM   = 3,
  parameter int CORR_SHIFT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_tick,
  input  logic carrier,
  input  logic rx_line,
  output logic rclk_en,
  output logic rx_data,
  output logic locked
);

  localparam int PRW = PW + 1 + CORR_SHIFT;
  localparam logic [PW-1:0] HALF = {1'b1, {(PW-1){1'b0}}};
  localparam logic [PW-1:0] INC  = PW'(STEP);

  typedef enum logic [1:0] {S_IDLE, S_HUNT, S_ARM, S_LOCK} st_t;

  st_t             state, state_n;
  logic [PW-1:0]   phase, phase_n;
  logic            line_q, samp;
  logic            fall, edge_seen, centre, tick;
  logic signed [PW:0] err;
  logic [PW:0]     err_mag;
  logic [PRW-1:0]  prod;
  logic [PW-1:0]   corr_mag;

  assign fall      = line_q & ~rx_line;
  assign edge_seen = line_q ^ rx_line;
  assign centre    = (phase[PW-1:PW-2] == 2'b01) || (phase[PW-1:PW-2] == 2'b10);
  assign err       = $signed({1'b0, phase}) - $signed({1'b0, HALF});
  assign err_mag   = err[PW] ? $unsigned(-err) : $unsigned(err);
  assign prod      = PRW'(err_mag) * PRW'(CORR_NUM);
  assign corr_mag  = prod[CORR_SHIFT +: PW];
  assign locked    = (state == S_LOCK);

  always_comb begin
    state_n = state;
    phase_n = phase + INC;
    case (state)
      S_IDLE: begin
        if (tx_tick) phase_n = '0;
        if (carrier) state_n = S_HUNT;
      end
      S_HUNT: begin
        if (!carrier) state_n = S_IDLE;
        else if (fall) begin
          state_n = S_ARM;
          phase_n = HALF;
        end
      end
      S_ARM: begin
        phase_n = phase;
        if (!carrier) state_n = S_IDLE;
        else if (fall) begin
          state_n = S_LOCK;
          phase_n = HALF;
        end
      end
      default: begin
        if (!carrier) state_n = S_IDLE;
        else if (edge_seen && centre)
          phase_n = err[PW] ? phase + INC + corr_mag : phase + INC - corr_mag;
      end
    endcase
  end

  assign tick = (state == S_LOCK) && (state_n == S_LOCK) &&
                (phase_n[PW-1:PW-2] == 2'b01) && (phase[PW-1:PW-2] != 2'b01);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      phase   <= '0;
      line_q  <= 1'b0;
      samp    <= 1'b1;
      rclk_en <= 1'b0;
      rx_data <= 1'b1;
    end else begin
      state   <= state_n;
      phase   <= phase_n;
      line_q  <= rx_line;
      rclk_en <= tick;
      if (state_n != S_LOCK) begin
        samp    <= 1'b1;
        rx_data <= 1'b1;
      end else if (tick) begin
        samp    <= ~rx_line;
        rx_data <= samp;
      end
    end
  end

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !carrier |=> (!locked && !rclk_en && rx_data));

  assert_txalign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && tx_tick) |=> (phase == '0));

  assert_lock_on_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(fall && carrier));

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rclk_en |=> !rclk_en);

  assert_corr_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOCK && edge_seen && centre) |->
      ((PW+5)'(corr_mag) * (PW+5)'(10) <= (PW+5)'(err_mag)));

  assert_no_early_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_LOCK && !carrier) |=> !locked);

endmodule

// File: tb/manch_acq_rx_bench.sv
`timescale 1ns/1ps
module manch_acq_rx_bench;

  logic clk = 1'b0, rst_n = 1'b0, tx_tick = 1'b0, carrier = 1'b0, rx_line = 1'b0;
  logic rclk_en, rx_data, locked;

  manch_acq_rx u_manch_acq_rx (
    .clk(clk), .rst_n(rst_n), .tx_tick(tx_tick), .carrier(carrier),
    .rx_line(rx_line), .rclk_en(rclk_en), .rx_data(rx_data), .locked(locked)
  );

  always #5 clk = ~clk;

  localparam int NV = 5;
  localparam logic [15:0] VPAY [NV] = '{16'hA5C3, 16'h0000, 16'hFFFF, 16'h1234, 16'hF00F};
  localparam int VAMP [NV] = '{0, 1, 2, 2, 1};

  int total = 0, bad = 0;
  int cyc = 0;
  int pkt_id = 0, seen_id = 0;
  int pcount = 0, first_cyc = 0, last_cyc = 0, min_iv = 1000, max_iv = 0;
  logic pdata [64];
  logic lock_seen = 1'b0;

  always @(posedge clk) cyc = cyc + 1;
  always @(negedge clk) tx_tick = (cyc % 16 == 0);

  always @(negedge clk) begin
    if (seen_id != pkt_id) begin
      seen_id = pkt_id; pcount = 0; min_iv = 1000; max_iv = 0; lock_seen = 1'b0;
    end
    if (locked) lock_seen = 1'b1;
    if (rclk_en) begin
      if (pcount == 0) first_cyc = cyc;
      else begin
        if (cyc - last_cyc < min_iv) min_iv = cyc - last_cyc;
        if (cyc - last_cyc > max_iv) max_iv = cyc - last_cyc;
      end
      last_cyc = cyc;
      if (pcount < 64) pdata[pcount] = rx_data;
      pcount = pcount + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_level(input logic lvl, input int n);
    repeat (n) begin
      @(negedge clk);
      rx_line = lvl;
    end
  endtask

  task automatic drive_cell(input logic b, input int j);
    drive_level(~b, 8 + j);
    drive_level(b, 8 - j);
  endtask

  task automatic send_pkt(input logic [15:0] pay, input int amp);
    int c0;
    int mism;
    pkt_id++;
    @(negedge clk);
    carrier = 1'b1;
    rx_line = 1'b0;
    drive_cell(1'b1, 0);
    drive_cell(1'b0, 0);
    drive_cell(1'b1, 0);
    drive_level(1'b1, 8);
    @(negedge clk);
    rx_line = 1'b0;
    c0 = cyc;
    check(locked == 1'b0, "R4 locked before second zero", int'(locked), 0);
    drive_level(1'b0, 1);
    check(locked == 1'b1, "R4 locked after second zero", int'(locked), 1);
    drive_level(1'b0, 6);
    for (int k = 0; k < 16; k++) begin
      int j;
      j = (amp == 0) ? 0 : (((k * 3 + pkt_id) % (2 * amp + 1)) - amp);
      drive_cell(pay[15-k], j);
    end
    drive_cell(1'b0, 0);
    @(negedge clk);
    carrier = 1'b0;
    rx_line = 1'b0;
    @(negedge clk);
    check(!locked && !rclk_en && rx_data, "R10 drop after lock",
          int'({locked, rclk_en, rx_data}), 1);
    check(first_cyc - c0 == 13, "R5 first pulse delay", first_cyc - c0, 13);
    check(pcount == 17, "R6 pulse count", pcount, 17);
    check(pdata[0] == 1'b1, "R7 first pulse data", int'(pdata[0]), 1);
    mism = 0;
    for (int k = 0; k < 16; k++) if (pdata[k+1] !== pay[15-k]) mism++;
    check(mism == 0, "R7 decoded payload mismatches", mism, 0);
    check(min_iv >= 15 && max_iv <= 17, "R8 pulse spacing max (min>=15)", max_iv, 17);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    int badidle;
    repeat (3) @(negedge clk);
    check(!locked && !rclk_en && rx_data, "R1 outputs in reset",
          int'({locked, rclk_en, rx_data}), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!locked && !rclk_en && rx_data, "R1 outputs after reset",
          int'({locked, rclk_en, rx_data}), 1);

    badidle = 0;
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      rx_line = (i % 5 == 0);
      if (locked || rclk_en || !rx_data) badidle++;
    end
    rx_line = 1'b0;
    check(badidle == 0, "R2 idle outputs quiet", badidle, 0);

    for (int v = 0; v < NV; v++) send_pkt(VPAY[v], VAMP[v]);

    pkt_id++;
    @(negedge clk);
    carrier = 1'b1;
    drive_level(1'b0, 30);
    drive_level(1'b1, 30);
    check(!lock_seen && pcount == 0, "R3 rising edges give no lock",
          int'(lock_seen) + pcount, 0);
    @(negedge clk);
    carrier = 1'b0;
    rx_line = 1'b0;
    repeat (10) @(negedge clk);

    pkt_id++;
    @(negedge clk);
    carrier = 1'b1;
    drive_cell(1'b1, 0);
    drive_cell(1'b0, 0);
    drive_cell(1'b1, 0);
    check(!lock_seen && pcount == 0, "R3 first zero gives no lock",
          int'(lock_seen) + pcount, 0);
    @(negedge clk);
    carrier = 1'b0;
    rx_line = 1'b0;
    repeat (10) @(negedge clk);
    check(!lock_seen, "R9 early drop never locks", int'(lock_seen), 0);
    send_pkt(16'h6B2D, 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule